// File: doc/BRIEF.md
# Polarity-Selectable Dual-Alignment PWM Channel

This block is one 8-bit pulse-width modulation channel. A counter advances on a channel clock enable (`tick`) produced elsewhere. The channel compares the count against an active period and an active duty value and drives one PWM output. A small write port reaches three registers: the period, the duty and the counter. Period and duty writes go into shadow registers. They reach the comparators only at a period boundary, on a counter write, or while the channel is disabled, so a waveform that is already running never sees a period that is half old and half new.

The `center` input selects the alignment. Left-aligned mode counts upward and wraps. Center-aligned mode counts up and then down, which gives twice the period for the same setting. The `pol` input sets the level the output starts each period with. A period of zero holds the output at that start level. A disabled channel freezes its counter and drives the opposite of `pol`. The current count is always visible on `count_o`.

Top module: `pwm_channel`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the active and shadow period are 0xFF, the active and shadow duty are 0x00, and the count direction is upward.
- R2: Write select codes: 0 writes the period shadow, 1 writes the duty shadow, 2 writes the counter and 3 does nothing. A counter write clears the count to 0 whatever the data, sets the direction upward and loads both active registers from the shadows. It takes priority over a tick in the same cycle.
- R3: In left-aligned mode (`center`=0) with period P>0, each cycle with `enable` and `tick` high moves the count up by one. A tick taken at P-1 or above wraps the count to 0. Cycles without a tick leave the count unchanged.
- R4: In center-aligned mode (`center`=1) with P>1, the count runs 0,1,..,P and then P-1,..,1, and returns to 0 on the next tick: 2P ticks per period. With P=1 it alternates between 0 and 1.
- R5: In left-aligned mode with 0<D<P, the output equals `pol` while count<D and equals the inverse of `pol` otherwise.
- R6: In center-aligned mode with D<P, the output equals `pol` while count<D on the upward slope and while count<=D on the downward slope. This gives 2D ticks at the `pol` level in each 2P-tick period.
- R7: With an active period of 0 and `enable` high, the output is constantly `pol`. Each tick holds the count at 0 and reloads the active registers.
- R8: With a nonzero active period and an active duty greater than or equal to it, the output is `pol` for the whole period.
- R9: The active period and duty load from the shadows only on a period-ending tick (the count returning to 0), on a counter write, or on any cycle with `enable` low. A write made mid-period leaves the current period unchanged.
- R10: While `enable` is low the count holds its value (except on a counter write), ticks are ignored, and the output is the inverse of `pol`.
- R11: `count_o` always shows the current count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Channel clock enable, one cycle per count step |
| enable | input | 1 | Channel run enable |
| pol | input | 1 | Start level of each period |
| center | input | 1 | 1 selects center-aligned mode, 0 selects left-aligned mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 counter, 3 none |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that `tick`, `enable`, `pol`, `center` and the write port are driven from the same clock and held steady around each edge. The output level checks also assume that `pol` is read in the cycle it applies to, because the output follows it combinationally. The stimulus changes every input only at the falling clock edge. It configures the channel with `tick` low before it clears the counter, and it changes the alignment mode only together with a counter write. This keeps the counter inside the range that the current period allows, which is the range the step and level properties reason about.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// Package: shared write-select encoding for the PWM channel.
// Assumes the write port carries a 2-bit select code.
package pwm_pkg;
    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } wsel_e;

    localparam int NUM_BUF_FIELDS = 2;
endpackage

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
// Module: pwm_shadow_regs
// Holds the double-buffered period and duty fields. Writes land in the
// shadow copy; the active copy follows the shadow whenever 'load' is high.
// Assumes 'load' is computed by the caller from the period boundary rules.
module pwm_shadow_regs
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] per_o,
    output logic [W-1:0] duty_o
);
    logic [W-1:0] shadow_q [NUM_BUF_FIELDS];
    logic [W-1:0] active_q [NUM_BUF_FIELDS];

    for (genvar g = 0; g < NUM_BUF_FIELDS; g++) begin : g_field
        localparam logic [W-1:0] RST_VAL = (g == 0) ? {W{1'b1}} : {W{1'b0}};
        localparam wsel_e        MY_SEL  = (g == 0) ? SEL_PERIOD : SEL_DUTY;

        // Capture writes addressed to this field into its shadow copy.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[g] <= RST_VAL;
            else if (wr_en && (wsel_e'(wr_sel) == MY_SEL))
                shadow_q[g] <= wr_data;
        end

        // Transfer shadow to active on a load event.
        always_ff @(posedge clk) begin
            if (!rst_n)
                active_q[g] <= RST_VAL;
            else if (load)
                active_q[g] <= shadow_q[g];
        end
    end

    assign per_o  = active_q[0];
    assign duty_o = active_q[1];
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
// Module: pwm_counter
// The channel counter, in up-only (left-aligned) or up/down (center-
// aligned) form. Flags the tick that ends a period. A clear forces zero
// and upward counting, and takes priority over a tick.
// Assumes 'per' is the active period and stays steady inside a period.
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         enable,
    input  logic         center,
    input  logic         clear,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt_o,
    output logic         up_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q, cnt_d;
    logic         up_q, up_d;
    logic         wrap;

    // Next count, direction and period-end flag.
    always_comb begin
        cnt_d = cnt_q;
        up_d  = up_q;
        wrap  = 1'b0;
        if (clear) begin
            cnt_d = ZERO;
            up_d  = 1'b1;
        end else if (enable && tick) begin
            if (per == ZERO) begin
                cnt_d = ZERO;
                up_d  = 1'b1;
                wrap  = 1'b1;
            end else if (!center) begin
                up_d = 1'b1;
                if (cnt_q >= per - ONE) begin
                    cnt_d = ZERO;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (up_q) begin
                if (cnt_q >= per) begin
                    if (per == ONE) begin
                        cnt_d = ZERO;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = per - ONE;
                        up_d  = 1'b0;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q <= ONE) begin
                    cnt_d = ZERO;
                    up_d  = 1'b1;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign up_o   = up_q;
    assign wrap_o = wrap;
endmodule

// File: rtl/pwm_wave.sv
`timescale 1ns/1ps
// Module: pwm_wave
// Turns count, direction and active settings into the output level.
// Handles disable, zero period and full-duty cases ahead of the compare.
// Assumes all inputs are registered or steady primary inputs.
module pwm_wave #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic [W-1:0] per,
    input  logic [W-1:0] duty,
    input  logic         enable,
    input  logic         pol,
    input  logic         center,
    output logic         pwm_o
);
    logic at_start_level;

    // Decide whether the output sits at its start level this cycle.
    always_comb begin
        if (per == '0)
            at_start_level = 1'b1;
        else if (duty >= per)
            at_start_level = 1'b1;
        else if (center && !up)
            at_start_level = (cnt <= duty);
        else
            at_start_level = (cnt < duty);
    end

    // Map the start-level decision and the enable onto the pin.
    always_comb begin
        if (!enable)
            pwm_o = ~pol;
        else
            pwm_o = at_start_level ? pol : ~pol;
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// Module: pwm_channel (top)
// One PWM channel: buffered period/duty, counter and output shaping.
// Assumes 'tick' is a one-cycle enable from an external prescaler and
// that all inputs are synchronous to clk.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         enable,
    input  logic         pol,
    input  logic         center,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic         pwm_o
);
    logic         cnt_clear;
    logic         buf_load;
    logic         period_end;
    logic         dir_up;
    logic [W-1:0] per_act;
    logic [W-1:0] duty_act;
    logic [W-1:0] cnt;

    // A counter write is any strobe carrying the counter select.
    assign cnt_clear = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
    // Shadow-to-active transfer events.
    assign buf_load  = cnt_clear || !enable || period_end;

    pwm_shadow_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (buf_load),
        .per_o   (per_act),
        .duty_o  (duty_act)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (enable),
        .center  (center),
        .clear   (cnt_clear),
        .per     (per_act),
        .cnt_o   (cnt),
        .up_o    (dir_up),
        .wrap_o  (period_end)
    );

    pwm_wave #(.W(W)) u_wave (
        .cnt     (cnt),
        .up      (dir_up),
        .per     (per_act),
        .duty    (duty_act),
        .enable  (enable),
        .pol     (pol),
        .center  (center),
        .pwm_o   (pwm_o)
    );

    assign count_o = cnt;
endmodule

// File: rtl/pwm_channel_chk.sv
`timescale 1ns/1ps
// Module: pwm_channel_chk
// Property checker bound into pwm_channel. Observes ports and the
// active period/duty held inside the channel.
module pwm_channel_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         enable,
    input logic         pol,
    input logic         center,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] count_o,
    input logic         pwm_o,
    input logic [W-1:0] per_act,
    input logic [W-1:0] duty_act
);
    logic cw;
    assign cw = wr_en && (wr_sel == 2'd2);

    // R10: a disabled channel drives the inverse of the polarity.
    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (pwm_o == ~pol));

    // R10: a disabled channel keeps its count unless cleared.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !cw) |=> (count_o == $past(count_o)));

    // R2: a counter write leaves zero in the count.
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (count_o == '0));

    // R7: zero period gives a constant start level.
    p_zero_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && per_act == '0) |-> (pwm_o == pol));

    // R8: duty at or above period gives a constant start level.
    p_full_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && per_act != '0 && duty_act >= per_act) |-> (pwm_o == pol));

    // R3: left-aligned counting steps by one below the wrap point.
    p_left_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && !center && !cw && per_act != '0
         && count_o < per_act - W'(1))
        |=> (count_o == $past(count_o) + W'(1)));

    // R3: without a tick the count does not move.
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cw) |=> $stable(count_o));
endmodule

bind pwm_channel pwm_channel_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (enable),
    .pol      (pol),
    .center   (center),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .count_o  (count_o),
    .pwm_o    (pwm_o),
    .per_act  (per_act),
    .duty_act (duty_act)
);

// File: tb/tb_pwm_channel.sv
`timescale 1ns/1ps
module tb_pwm_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       enable = 1'b0;
    logic       pol = 1'b1;
    logic       center = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_o;
    logic       pwm_o;

    int checks = 0;
    int failures = 0;
    bit compare_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt, m_per, m_duty, m_sper, m_sduty;
    bit m_up;

    pwm_channel dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .pol(pol),
        .center(center), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count_o(count_o), .pwm_o(pwm_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_out();
        if (!enable) return ~pol;
        if (m_per == 0) return pol;
        if (m_duty >= m_per) return pol;
        if (center && !m_up) return (m_cnt <= m_duty) ? pol : ~pol;
        return (m_cnt < m_duty) ? pol : ~pol;
    endfunction

    // reference model update, using inputs held since the falling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_per = 255; m_duty = 0; m_sper = 255; m_sduty = 0;
        end else begin
            bit wrap_ev;
            wrap_ev = 0;
            if (wr_en && wr_sel == 2) begin
                m_cnt = 0; m_up = 1; m_per = m_sper; m_duty = m_sduty;
            end else if (!enable) begin
                m_per = m_sper; m_duty = m_sduty;
            end else if (tick) begin
                if (m_per == 0) begin
                    m_cnt = 0; m_up = 1; wrap_ev = 1;
                end else if (!center) begin
                    m_up = 1;
                    if (m_cnt >= m_per - 1) begin m_cnt = 0; wrap_ev = 1; end
                    else m_cnt++;
                end else if (m_up) begin
                    if (m_cnt >= m_per) begin
                        if (m_per == 1) begin m_cnt = 0; wrap_ev = 1; end
                        else begin m_cnt = m_per - 1; m_up = 0; end
                    end else m_cnt++;
                end else begin
                    if (m_cnt <= 1) begin m_cnt = 0; m_up = 1; wrap_ev = 1; end
                    else m_cnt--;
                end
                if (wrap_ev) begin m_per = m_sper; m_duty = m_sduty; end
            end
            if (wr_en && wr_sel == 0) m_sper = wr_data;
            if (wr_en && wr_sel == 1) m_sduty = wr_data;
        end
    end

    // per-cycle comparison against the model, clear of both edges
    always @(negedge clk) begin
        #5;
        if (compare_on && rst_n) begin
            check("R11 count_o vs model", count_o, m_cnt);
            check("R5/R6 pwm_o vs model", pwm_o, model_out());
        end
    end

    task automatic write(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic run(input int n, output int at_pol, output int max_cnt);
        at_pol = 0; max_cnt = 0;
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            if (pwm_o == pol) at_pol++;
            if (count_o > max_cnt) max_cnt = count_o;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hp, mx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #6;
        check("R1 reset count", count_o, 0);
        check("R10 disabled level after reset", pwm_o, 0);
        compare_on = 1'b1;

        // R1: default period 0xFF, duty 0 -> left wrap after 255 ticks
        enable = 1'b1; pol = 1'b1;
        run(255, hp, mx);
        check("R1 default period max count", mx, 254);
        check("R1 default period wrapped", count_o, 0);

        // R5: left P=10 D=3, pol=1
        write(2'd0, 8'd10);
        write(2'd1, 8'd3);
        write(2'd2, 8'd0);
        run(10, hp, mx);
        check("R5 left high ticks", hp, 3);
        check("R3 left max count", mx, 9);
        check("R3 left wrap to zero", count_o, 0);

        // R3: no tick, no movement
        run(4, hp, mx);
        repeat (3) @(negedge clk);
        #6;
        check("R3 hold without tick", count_o, 4);

        // R2: counter write with arbitrary data clears; select 3 ignored
        write(2'd3, 8'd1);
        #6;
        check("R2 select 3 ignored", count_o, 4);
        write(2'd2, 8'hAB);
        #6;
        check("R2 counter write clears", count_o, 0);

        // R9: mid-period period change waits for the boundary
        run(4, hp, mx);
        write(2'd0, 8'd3);
        run(6, hp, mx);
        check("R9 old period still active", mx, 9);
        check("R9 wrap at old period", count_o, 0);
        run(3, hp, mx);
        check("R9 new period max", mx, 2);
        check("R9 new period wrap", count_o, 0);

        // R6/R4: center P=6 D=2 pol=0
        pol = 1'b0; center = 1'b1;
        write(2'd0, 8'd6);
        write(2'd1, 8'd2);
        write(2'd2, 8'd0);
        run(12, hp, mx);
        check("R6 center start-level ticks", hp, 4);
        check("R4 center peak", mx, 6);
        check("R4 center returns to zero", count_o, 0);

        // R4: center P=1
        write(2'd0, 8'd1);
        write(2'd2, 8'd0);
        run(1, hp, mx);
        #6;
        check("R4 P=1 reaches one", count_o, 1);
        run(1, hp, mx);
        #6;
        check("R4 P=1 back to zero", count_o, 0);

        // R8: duty above period, left mode
        center = 1'b0; pol = 1'b1;
        write(2'd0, 8'd5);
        write(2'd1, 8'd9);
        write(2'd2, 8'd0);
        run(5, hp, mx);
        check("R8 full duty ticks", hp, 5);

        // R7: zero period, pol 1 then 0
        write(2'd0, 8'd0);
        write(2'd2, 8'd0);
        run(5, hp, mx);
        check("R7 zero period constant high", hp, 5);
        check("R7 zero period count held", mx, 0);
        pol = 1'b0;
        run(3, hp, mx);
        check("R7 zero period constant low", hp, 3);

        // R10: disable freezes count, output inverted
        write(2'd0, 8'd20);
        write(2'd1, 8'd10);
        write(2'd2, 8'd0);
        pol = 1'b1;
        run(6, hp, mx);
        enable = 1'b0;
        run(5, hp, mx);
        #6;
        check("R10 count frozen", count_o, 6);
        check("R10 disabled level", pwm_o, 0);
        check("R10 no start level while off", hp, 0);
        enable = 1'b1;
        run(2, hp, mx);
        #6;
        check("R10 resumes counting", count_o, 8);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule